// File: doc/BRIEF.md
# Timestamped Action Queue with Register Readout

This block collects actions that an upstream event matcher hands over and holds them in order until software collects them. Each stored action carries a 64-bit deadline and four error flags (late, early, conflict, delayed). The matcher offers one action per cycle on a simple push strobe, and the block accepts it unless the queue is already full.

Software sees only the oldest action. It reads it through a small register map on a 32-bit Wishbone slave: a flags word whose top flag says whether the oldest slot holds data, and the deadline split into an upper and a lower word. Any write to the discard register drops the oldest action, so the next one comes into view. A fixed identifier lets software tell several such queues apart. The slave has no writable data register, so it has no write data bus. Its address input is a word address, so word index n sits at byte offset 4*n.

Top module: `action_queue_regs`

## Requirements
- R1: After reset the queue is empty, a flags read returns 0x00, both deadline words read 0 and `wb_ack` is low.
- R2: A read of word 0 (byte offset 0x00) returns the parameter QUEUE_ID (default 2). Writes there change nothing.
- R3: A request (cyc and stb high while ack is low) is acknowledged in the next cycle with `wb_ack` high for exactly one cycle.
- R4: Word 2 (offset 0x08) returns the flags: bit 0 late, bit 1 early, bit 2 conflict, bit 3 delayed, bit 4 valid, and bits 31:5 read 0. Valid is 1 exactly when the queue holds at least one action.
- R5: Word 10 (offset 0x28) returns deadline bits 63:32 of the oldest action, and word 11 (offset 0x2C) returns bits 31:0.
- R6: Any write to word 1 (offset 0x04) removes the oldest action. Actions leave in the order they were pushed.
- R7: A discard while the queue is empty has no effect: an action pushed afterwards is still read out intact.
- R8: Once the last action has been removed, flags bits 3:0 keep the error flags of the action removed last while bit 4 reads 0. They are 0 before any removal.
- R9: While the queue is empty both deadline words read 0.
- R10: The queue holds DEPTH (default 16) actions. A push while it is full is dropped, and an internal overflow mark is set and stays set until reset.
- R11: Reads of word 1 and of unmapped words (for example word 4, offset 0x10) return 0, and writes to read-only words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Matcher offers an action this cycle |
| push_deadline | input | 64 | Deadline of the offered action |
| push_err | input | 4 | Error flags of the offered action (bit 0 late, 1 early, 2 conflict, 3 delayed) |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | WORD_ADR_W | Word address (byte offset divided by 4) |
| wb_ack | output | 1 | Wishbone acknowledge |
| wb_dat_o | output | 32 | Registered read data |

## Verification
On every cycle, the assertions check the one-cycle acknowledge, the identifier value, that the valid flag follows the fill state, that deadlines read zero when the queue is empty, that a discard on an empty queue does nothing, that the fill level stays put when a push meets a full queue, and that the overflow mark does not clear. Only the bench scenarios can show that actions leave in push order, that the deadline words carry the right halves, that the error bits stay visible after the last removal, and that the seventeenth push in a row is lost.

// File: rtl/aq_pkg.sv
package aq_pkg;
  localparam int DL_W   = 64;
  localparam int ERR_W  = 4;
  localparam int DATA_W = 32;
  localparam int VALID_BIT = 4;

  typedef struct packed {
    logic [DL_W-1:0]  deadline;
    logic [ERR_W-1:0] err;
  } aq_entry_t;

  localparam int ENTRY_W = $bits(aq_entry_t);

  // word indices of the register map (byte offset = 4 * index)
  localparam logic [3:0] IDX_ID    = 4'd0;
  localparam logic [3:0] IDX_POP   = 4'd1;
  localparam logic [3:0] IDX_FLAGS = 4'd2;
  localparam logic [3:0] IDX_DL_HI = 4'd10;
  localparam logic [3:0] IDX_DL_LO = 4'd11;
endpackage

// File: rtl/aq_fifo.sv
module aq_fifo #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 68,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && !do_push) overflow_o <= 1'b1;
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count;
endmodule

// File: rtl/aq_head_view.sv
module aq_head_view
  import aq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  aq_entry_t         head_i,
  input  logic              empty_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] flags_word_o,
  output logic [DATA_W-1:0] dl_hi_o,
  output logic [DATA_W-1:0] dl_lo_o
);
  logic [ERR_W-1:0] last_err;

  // error bits of the entry removed last stay visible once the queue drains
  always_ff @(posedge clk) begin
    if (rst)                     last_err <= '0;
    else if (pop_i && !empty_i)  last_err <= head_i.err;
  end

  always_comb begin
    flags_word_o = '0;
    if (empty_i) begin
      flags_word_o[ERR_W-1:0] = last_err;
      dl_hi_o = '0;
      dl_lo_o = '0;
    end else begin
      flags_word_o[ERR_W-1:0] = head_i.err;
      flags_word_o[VALID_BIT] = 1'b1;
      dl_hi_o = head_i.deadline[DL_W-1:DATA_W];
      dl_lo_o = head_i.deadline[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/aq_wb_regs.sv
module aq_wb_regs
  import aq_pkg::*;
#(
  parameter int WORD_ADR_W = 6,
  parameter int QUEUE_ID   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cyc_i,
  input  logic                  stb_i,
  input  logic                  we_i,
  input  logic [WORD_ADR_W-1:0] adr_i,
  input  logic [DATA_W-1:0]     flags_i,
  input  logic [DATA_W-1:0]     dl_hi_i,
  input  logic [DATA_W-1:0]     dl_lo_i,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     dat_o,
  output logic                  pop_o
);
  logic req;
  logic [DATA_W-1:0] rd_mux;

  assign req   = cyc_i && stb_i && !ack_o;
  assign pop_o = req && we_i && (adr_i == WORD_ADR_W'(IDX_POP));

  always_comb begin
    rd_mux = '0;
    if      (adr_i == WORD_ADR_W'(IDX_ID))    rd_mux = DATA_W'(QUEUE_ID);
    else if (adr_i == WORD_ADR_W'(IDX_FLAGS)) rd_mux = flags_i;
    else if (adr_i == WORD_ADR_W'(IDX_DL_HI)) rd_mux = dl_hi_i;
    else if (adr_i == WORD_ADR_W'(IDX_DL_LO)) rd_mux = dl_lo_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      dat_o <= '0;
    end else begin
      ack_o <= req;
      dat_o <= (req && !we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/action_queue_regs.sv
module action_queue_regs
  import aq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WORD_ADR_W = 6,
  parameter int QUEUE_ID   = 2,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push_valid,
  input  logic [DL_W-1:0]       push_deadline,
  input  logic [ERR_W-1:0]      push_err,
  input  logic                  wb_cyc,
  input  logic                  wb_stb,
  input  logic                  wb_we,
  input  logic [WORD_ADR_W-1:0] wb_adr,
  output logic                  wb_ack,
  output logic [DATA_W-1:0]     wb_dat_o
);
  aq_entry_t         in_entry, head;
  logic [ENTRY_W-1:0] head_bits;
  logic              q_empty, q_full, q_overflow, pop_req;
  logic [CNT_W-1:0]  q_count;
  logic [DATA_W-1:0] flags_word, dl_hi, dl_lo;

  assign in_entry.deadline = push_deadline;
  assign in_entry.err      = push_err;
  assign head              = aq_entry_t'(head_bits);

  aq_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push_i(push_valid), .push_data_i(in_entry),
    .pop_i(pop_req), .head_o(head_bits),
    .empty_o(q_empty), .full_o(q_full),
    .count_o(q_count), .overflow_o(q_overflow)
  );

  aq_head_view u_view (
    .clk(clk), .rst(rst),
    .head_i(head), .empty_i(q_empty), .pop_i(pop_req),
    .flags_word_o(flags_word), .dl_hi_o(dl_hi), .dl_lo_o(dl_lo)
  );

  aq_wb_regs #(.WORD_ADR_W(WORD_ADR_W), .QUEUE_ID(QUEUE_ID)) u_regs (
    .clk(clk), .rst(rst),
    .cyc_i(wb_cyc), .stb_i(wb_stb), .we_i(wb_we), .adr_i(wb_adr),
    .flags_i(flags_word), .dl_hi_i(dl_hi), .dl_lo_i(dl_lo),
    .ack_o(wb_ack), .dat_o(wb_dat_o), .pop_o(pop_req)
  );
endmodule

// File: rtl/aq_checker.sv
module aq_checker
  import aq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WORD_ADR_W = 6,
  parameter int QUEUE_ID   = 2,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  push_valid,
  input logic                  wb_cyc,
  input logic                  wb_stb,
  input logic                  wb_we,
  input logic [WORD_ADR_W-1:0] wb_adr,
  input logic                  wb_ack,
  input logic [DATA_W-1:0]     wb_dat_o,
  input logic                  q_empty,
  input logic [CNT_W-1:0]      q_count,
  input logic                  q_overflow
);
  logic req, rd_req, pop_wr;
  assign req    = wb_cyc && wb_stb && !wb_ack;
  assign rd_req = req && !wb_we;
  assign pop_wr = req && wb_we && (wb_adr == WORD_ADR_W'(IDX_POP));

  a_r3_ack_next: assert property (@(posedge clk) disable iff (rst)
    req |=> wb_ack);
  a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);
  a_r2_id_value: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wb_adr == WORD_ADR_W'(IDX_ID)) |=> (wb_dat_o == DATA_W'(QUEUE_ID)));
  a_r4_valid_tracks_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wb_adr == WORD_ADR_W'(IDX_FLAGS)) |=> (wb_dat_o[VALID_BIT] == !$past(q_empty)));
  a_r9_empty_deadline_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && q_empty && (wb_adr == WORD_ADR_W'(IDX_DL_HI) || wb_adr == WORD_ADR_W'(IDX_DL_LO)))
      |=> (wb_dat_o == '0));
  a_r7_pop_empty_noop: assert property (@(posedge clk) disable iff (rst)
    (pop_wr && q_empty && !push_valid) |=> q_empty);
  a_r10_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push_valid && q_count == CNT_W'(DEPTH) && !pop_wr) |=> (q_count == CNT_W'(DEPTH)));
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    q_overflow |=> q_overflow);
endmodule

bind action_queue_regs aq_checker #(
  .DEPTH(DEPTH), .WORD_ADR_W(WORD_ADR_W), .QUEUE_ID(QUEUE_ID)
) u_aq_checker (
  .clk(clk), .rst(rst), .push_valid(push_valid),
  .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
  .wb_ack(wb_ack), .wb_dat_o(wb_dat_o),
  .q_empty(q_empty), .q_count(q_count), .q_overflow(q_overflow)
);

// File: tb/action_queue_regs_bench.sv
`timescale 1ns/1ps
module action_queue_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [63:0] push_deadline = '0;
  logic [3:0]  push_err = '0;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [5:0]  wb_adr = '0;
  logic        wb_ack;
  logic [31:0] wb_dat_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  action_queue_regs u_action_queue_regs (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_deadline(push_deadline),
    .push_err(push_err), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_ack(wb_ack), .wb_dat_o(wb_dat_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles (expected end of test)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // request at a falling edge; ack and data appear after the next rising edge
  task automatic bus(input logic wr, input logic [5:0] adr, output logic [31:0] rd);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = wr; wb_adr = adr;
    @(negedge clk);
    chk("R3 ack after request", 32'(wb_ack), 32'd1);
    rd = wb_dat_o;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    @(negedge clk);
    chk("R3 ack single cycle", 32'(wb_ack), 32'd0);
  endtask

  task automatic push(input logic [63:0] dl, input logic [3:0] er);
    @(negedge clk);
    push_valid = 1'b1; push_deadline = dl; push_err = er;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // vector: {req[3:0], op[1:0] (0 read, 1 write, 2 push), word adr[5:0], data[31:0], expected[31:0]}
  // push uses deadline {data, ~data} and error flags data[3:0]
  localparam int NV = 20;
  localparam logic [75:0] VECS [NV] = '{
    {4'd1,  2'd0, 6'h02, 32'h0,          32'h00000000}, // R1 flags empty
    {4'd2,  2'd0, 6'h00, 32'h0,          32'h00000002}, // R2 identifier
    {4'd9,  2'd0, 6'h0A, 32'h0,          32'h00000000}, // R9 hi empty
    {4'd6,  2'd2, 6'h00, 32'h11110001,   32'h0},        // R6 push first
    {4'd6,  2'd2, 6'h00, 32'h2222000A,   32'h0},        // R6 push second
    {4'd4,  2'd0, 6'h02, 32'h0,          32'h00000011}, // R4 valid + late
    {4'd5,  2'd0, 6'h0A, 32'h0,          32'h11110001}, // R5 upper word
    {4'd5,  2'd0, 6'h0B, 32'h0,          32'hEEEEFFFE}, // R5 lower word
    {4'd11, 2'd0, 6'h01, 32'h0,          32'h00000000}, // R11 pop reads 0
    {4'd6,  2'd1, 6'h01, 32'h0,          32'h0},        // R6 discard
    {4'd6,  2'd0, 6'h02, 32'h0,          32'h0000001A}, // R6 second in view
    {4'd6,  2'd0, 6'h0B, 32'h0,          32'hDDDDFFF5}, // R6 second lower
    {4'd11, 2'd1, 6'h00, 32'h0,          32'h0},        // R11 write to id
    {4'd11, 2'd0, 6'h00, 32'h0,          32'h00000002}, // R11 id unchanged
    {4'd6,  2'd1, 6'h01, 32'h0,          32'h0},        // R6 discard last
    {4'd8,  2'd0, 6'h02, 32'h0,          32'h0000000A}, // R8 error bits kept
    {4'd9,  2'd0, 6'h0B, 32'h0,          32'h00000000}, // R9 lower empty
    {4'd11, 2'd0, 6'h04, 32'h0,          32'h00000000}, // R11 unmapped
    {4'd7,  2'd1, 6'h01, 32'h0,          32'h0},        // R7 discard empty
    {4'd7,  2'd0, 6'h02, 32'h0,          32'h0000000A}  // R7 flags unchanged
  };

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ack low after reset", 32'(wb_ack), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VECS[i];
      case (v[71:70])
        2'd2: push({v[63:32], ~v[63:32]}, v[35:32]);
        2'd1: bus(1'b1, v[69:64], rd);
        default: begin
          bus(1'b0, v[69:64], rd);
          chk($sformatf("R%0d vector %0d", v[75:72], i), rd, v[31:0]);
        end
      endcase
    end

    // R7: a pushed entry after the empty discard is intact
    push({32'h55, 32'h66}, 4'h4);
    bus(1'b0, 6'h02, rd); chk("R7 flags after push", rd, 32'h14);
    bus(1'b0, 6'h0B, rd); chk("R7 lower after push", rd, 32'h66);
    bus(1'b1, 6'h01, rd);
    bus(1'b0, 6'h02, rd); chk("R7 empty again", rd, 32'h04);

    // R10: seventeen pushes, only sixteen survive, in order
    for (int i = 0; i < 17; i++) push({32'hA0000000 + 32'(i), 32'(i)}, 4'h0);
    for (int i = 0; i < 16; i++) begin
      bus(1'b0, 6'h0B, rd); chk($sformatf("R10 order entry %0d", i), rd, 32'(i));
      bus(1'b1, 6'h01, rd);
    end
    bus(1'b0, 6'h02, rd); chk("R10 dropped push leaves queue empty", rd, 32'h00);
    bus(1'b0, 6'h0A, rd); chk("R9 upper zero when drained", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule